// File: doc/BRIEF.md
# Triple Match Timer

This peripheral holds three independent 32-bit counters behind a small register bus of the APB kind. Each counter has a running count, a reload value, two compare values and a wrap detector. Every counter can count up or down. It can advance on every bus clock or on rising edges of an external tick line, and it raises three event kinds: compare A, compare B and wrap. A shared control word holds the per-counter settings. A sticky event word and a blocking mask cover all nine events, and one combined interrupt line leaves the block.

A typical use is a periodic tick: preload an up-counter with `0xFFFFFFFF - (P-1)`, put the same value in its reload register, and let the wrap event fire every P ticks. Another use is a free-running counter that software reads, with a compare value written ahead of the current count to request a one-shot event.

The bus side is tracked by a three-state phase machine. BUS_IDLE moves to BUS_ADDR when a setup phase is seen (select high, enable low). BUS_ADDR always moves to BUS_DATA if select stays high and returns to BUS_IDLE otherwise. BUS_DATA moves back to BUS_ADDR on a new setup phase, stays in BUS_DATA while an access is held, and returns to BUS_IDLE when select drops. A write commits only in the access cycle that directly follows BUS_ADDR.

Top module: `tri_match_timer`

## Requirements
- R1: After reset every register reads 0. Byte addresses are as follows. Counter n (n = 1..3) has its base at 0x10*(n-1), with count at +0x0, reload at +0x4, compare A at +0x8 and compare B at +0xC. Control is at 0x30, event status at 0x34 and mask at 0x38. Any other address reads 0.
- R2: Control bit 3(n-1) enables counter n and bit 9+(n-1) selects up (1) or down (0). An enabled counter moves by one per tick. A counter whose enable bit is 0 keeps its count.
- R3: When an up-counter steps from 0xFFFFFFFF, it loads its reload value and sets event bit 3(n-1)+2.
- R4: When a down-counter steps from 0, it loads its reload value and sets event bit 3(n-1)+2.
- R5: A step whose new count equals compare A sets event bit 3(n-1). A step whose new count equals compare B sets event bit 3(n-1)+1. An idle counter raises no events.
- R6: A bus write to a count register takes effect at its commit edge, even while the counter runs. It takes the place of that cycle's step and raises no event.
- R7: Control bit 3(n-1)+1 selects the tick source for counter n: 0 means every bus clock, 1 means one step per rising edge of `ext_tick`, seen through a two-flop synchroniser.
- R8: Event status bits are sticky. Writing 0 to a bit clears it and writing 1 leaves it unchanged. An event in the same cycle as a clear keeps its bit set.
- R9: `irq` is the OR of the status bits whose mask bit is 0 and whose counter has its interrupt-enable bit (control bit 3(n-1)+2) set.
- R10: A write commits only once, in the access cycle right after a setup phase. An access cycle with no setup phase in front of it writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for the addressed register |
| ext_tick | input | 1 | External tick line, asynchronous |
| irq | output | 1 | Combined interrupt |

## Verification
The bench runs each counter across its wrap point. A wrong reload would show up as a bad count after two periods, and a dropped wrap event as a missing status bit. It counts a down-counter through zero and writes the count of a running counter, where an off-by-one between write and step would shift the final value. It checks that writing ones to the status word keeps bits and writing zeros clears them. It toggles interrupt enable and mask to show `irq` follows both. It leaves a counter on the external source with no edges to prove the bus clock does not leak through. Finally it drives an access cycle with no setup phase, which a decoder that ignores the phase would commit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {BUS_IDLE, BUS_ADDR, BUS_DATA} bus_st_e;

    // event bit order inside one counter's group
    localparam int EV_CMPA = 0;
    localparam int EV_CMPB = 1;
    localparam int EV_WRAP = 2;
    localparam int EV_PER  = 3;

    // control bit order inside one counter's group
    localparam int CF_RUN  = 0;
    localparam int CF_SRC  = 1;
    localparam int CF_IEN  = 2;
    localparam int CF_PER  = 3;

    // word offsets inside one counter's window
    localparam int W_CNT   = 0;
    localparam int W_RLD   = 1;
    localparam int W_CMPA  = 2;
    localparam int W_CMPB  = 3;
    localparam int W_PER   = 4;
endpackage

// File: rtl/tick_sync.sv
module tick_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic tick_pulse
);
    logic [2:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], tick_in};
    end

    assign tick_pulse = sh_q[1] & ~sh_q[2];

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> !tick_pulse);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          up,
    input  logic          tick,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    input  logic [CW-1:0] reload,
    input  logic [CW-1:0] cmp_a,
    input  logic [CW-1:0] cmp_b,
    output logic [CW-1:0] count,
    output logic [2:0]    ev
);
    import tmr_pkg::*;

    localparam logic [CW-1:0] TOP = '1;

    logic          adv;
    logic          wrap;
    logic [CW-1:0] nxt;

    always_comb begin
        adv  = run & tick;
        wrap = up ? (count == TOP) : (count == '0);
        if (wrap)    nxt = reload;
        else if (up) nxt = count + 1'b1;
        else         nxt = count - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (cnt_we) count <= cnt_wdata;
        else if (adv)    count <= nxt;
    end

    always_comb begin
        ev          = '0;
        ev[EV_WRAP] = adv & ~cnt_we & wrap;
        ev[EV_CMPA] = adv & ~cnt_we & (nxt == cmp_a);
        ev[EV_CMPB] = adv & ~cnt_we & (nxt == cmp_b);
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !cnt_we) |=> $stable(count));
    // R3
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && up && !cnt_we && count == TOP) |=> (count == $past(reload)));
    // R4
    down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !up && !cnt_we && count == '0) |=> (count == $past(reload)));
    // R6
    sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (count == $past(cnt_wdata)));
endmodule

// File: rtl/bus_phase.sv
module bus_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_stb
);
    import tmr_pkg::*;

    bus_st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_IDLE: if (psel && !penable) st_d = BUS_ADDR;
            BUS_ADDR: st_d = psel ? BUS_DATA : BUS_IDLE;
            BUS_DATA: begin
                if (!psel)         st_d = BUS_IDLE;
                else if (!penable) st_d = BUS_ADDR;
                else               st_d = BUS_DATA;
            end
            default:  st_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        wr_stb = (st_q == BUS_ADDR) && psel && penable && pwrite;
    end

    // R10
    one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
endmodule

// File: rtl/tri_match_timer.sv
module tri_match_timer #(
    parameter int N_TMR  = 3,
    parameter int CW     = 32,
    parameter int DW     = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DW-1:0]     pwdata,
    output logic [DW-1:0]     prdata,
    input  logic              ext_tick,
    output logic              irq
);
    import tmr_pkg::*;

    localparam int IDX_W  = ADDR_W - 2;
    localparam int EV_W   = EV_PER * N_TMR;
    localparam int CTL_W  = (CF_PER + 1) * N_TMR;
    localparam int DIR_LO = CF_PER * N_TMR;
    localparam int SH_IDX = W_PER * N_TMR;
    localparam logic [IDX_W-1:0] I_CTL  = IDX_W'(SH_IDX);
    localparam logic [IDX_W-1:0] I_STAT = IDX_W'(SH_IDX + 1);
    localparam logic [IDX_W-1:0] I_MASK = IDX_W'(SH_IDX + 2);

    logic             wr_stb;
    logic             ext_pulse;
    logic [IDX_W-1:0] widx;
    logic [CTL_W-1:0] ctrl_q;
    logic [EV_W-1:0]  stat_q, mask_q, ev_all, ien_x;
    logic [CW-1:0]    cnt_a  [N_TMR];
    logic [CW-1:0]    rld_a  [N_TMR];
    logic [CW-1:0]    cmpa_a [N_TMR];
    logic [CW-1:0]    cmpb_a [N_TMR];

    assign widx = paddr[ADDR_W-1:2];

    bus_phase u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .wr_stb  (wr_stb)
    );

    tick_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_in    (ext_tick),
        .tick_pulse (ext_pulse)
    );

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        localparam logic [IDX_W-1:0] I_CNT  = IDX_W'(t * W_PER + W_CNT);
        localparam logic [IDX_W-1:0] I_RLD  = IDX_W'(t * W_PER + W_RLD);
        localparam logic [IDX_W-1:0] I_CMPA = IDX_W'(t * W_PER + W_CMPA);
        localparam logic [IDX_W-1:0] I_CMPB = IDX_W'(t * W_PER + W_CMPB);

        logic cnt_we;
        logic tick;

        assign cnt_we = wr_stb && (widx == I_CNT);
        assign tick   = ctrl_q[t*CF_PER + CF_SRC] ? ext_pulse : 1'b1;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rld_a[t]  <= '0;
                cmpa_a[t] <= '0;
                cmpb_a[t] <= '0;
            end else if (wr_stb) begin
                if (widx == I_RLD)  rld_a[t]  <= pwdata[CW-1:0];
                if (widx == I_CMPA) cmpa_a[t] <= pwdata[CW-1:0];
                if (widx == I_CMPB) cmpb_a[t] <= pwdata[CW-1:0];
            end
        end

        for (genvar k = 0; k < EV_PER; k++) begin : g_ien
            assign ien_x[t*EV_PER + k] = ctrl_q[t*CF_PER + CF_IEN];
        end

        tmr_chan #(.CW(CW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (ctrl_q[t*CF_PER + CF_RUN]),
            .up        (ctrl_q[DIR_LO + t]),
            .tick      (tick),
            .cnt_we    (cnt_we),
            .cnt_wdata (pwdata[CW-1:0]),
            .reload    (rld_a[t]),
            .cmp_a     (cmpa_a[t]),
            .cmp_b     (cmpb_a[t]),
            .count     (cnt_a[t]),
            .ev        (ev_all[t*EV_PER +: EV_PER])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            if (wr_stb && widx == I_CTL)  ctrl_q <= pwdata[CTL_W-1:0];
            if (wr_stb && widx == I_MASK) mask_q <= pwdata[EV_W-1:0];
            if (wr_stb && widx == I_STAT) stat_q <= (stat_q & pwdata[EV_W-1:0]) | ev_all;
            else                          stat_q <= stat_q | ev_all;
        end
    end

    assign irq = |(stat_q & ~mask_q & ien_x);

    always_comb begin
        prdata = '0;
        for (int t = 0; t < N_TMR; t++) begin
            if (widx == IDX_W'(t * W_PER + W_CNT))  prdata[CW-1:0] = cnt_a[t];
            if (widx == IDX_W'(t * W_PER + W_RLD))  prdata[CW-1:0] = rld_a[t];
            if (widx == IDX_W'(t * W_PER + W_CMPA)) prdata[CW-1:0] = cmpa_a[t];
            if (widx == IDX_W'(t * W_PER + W_CMPB)) prdata[CW-1:0] = cmpb_a[t];
        end
        if (widx == I_CTL)  prdata[CTL_W-1:0] = ctrl_q;
        if (widx == I_STAT) prdata[EV_W-1:0]  = stat_q;
        if (widx == I_MASK) prdata[EV_W-1:0]  = mask_q;
    end

    // R8
    ev_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_all) |=> ((stat_q & $past(ev_all)) == $past(ev_all)));
    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(stat_q & ~mask_q)));
    // R1
    rst_ctl_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (ctrl_q == '0 && stat_q == '0));
endmodule

// File: tb/sim_tri_match_timer.sv
module sim_tri_match_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, ext_tick = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct { string tag; logic [31:0] exp; } item_t;
    item_t sbq[$];

    localparam logic [31:0] V5 = 32'hFFFF_FFFB;

    always #10 clk = ~clk;

    tri_match_timer u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ext_tick(ext_tick), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        paddr = a; pwdata = d; pwrite = 1'b1; psel = 1'b1; penable = 1'b0;
        @(negedge clk) penable = 1'b1;
        @(negedge clk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        item_t it;
        it.tag = tag; it.exp = exp;
        sbq.push_back(it);
        paddr = a; pwrite = 1'b0; psel = 1'b1; penable = 1'b0;
        @(negedge clk) penable = 1'b1;
        @(negedge clk) begin psel = 1'b0; penable = 1'b0; end
    endtask

    // monitor: compares read data in the middle of each access phase
    initial forever begin
        @(posedge clk);
        #4;
        if (psel && penable && !pwrite) begin
            if (sbq.size() == 0) check("SB empty", prdata, 32'hxxxx_xxxx);
            else begin
                item_t it;
                it = sbq.pop_front();
                check(it.tag, prdata, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset values and unmapped address
        rd(8'h30, 32'h0, "R1 ctrl");
        rd(8'h34, 32'h0, "R1 status");
        rd(8'h38, 32'h0, "R1 mask");
        rd(8'h00, 32'h0, "R1 count1");
        rd(8'h3C, 32'h0, "R1 unmapped");
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R6 software count write, R2 up counting for 10 steps then frozen
        wr(8'h00, 32'd1000);
        wr(8'h30, 32'h201);
        idle(8);
        wr(8'h30, 32'h0);
        rd(8'h00, 32'd1010, "R6 R2 count after run");
        idle(5);
        rd(8'h00, 32'd1010, "R2 frozen");

        // R6 write while running
        wr(8'h30, 32'h201);
        idle(3);
        wr(8'h00, 32'd50);
        idle(4);
        wr(8'h30, 32'h0);
        rd(8'h00, 32'd56, "R6 write while running");

        // R3 up wrap with period 5, 12 steps
        wr(8'h04, V5);
        wr(8'h00, V5);
        wr(8'h30, 32'h201);
        idle(10);
        wr(8'h30, 32'h0);
        rd(8'h00, V5 + 32'd2, "R3 count after two wraps");
        rd(8'h34, 32'h4, "R3 wrap event bit 2");

        // R8 write ones keeps, write zeros clears
        wr(8'h34, 32'h1FF);
        rd(8'h34, 32'h4, "R8 ones keep");
        wr(8'h34, 32'hFFFF_FFFB);
        rd(8'h34, 32'h0, "R8 zero clears");

        // R5 compare A on counter 2
        wr(8'h18, 32'd7);
        wr(8'h1C, 32'd100);
        wr(8'h10, 32'd0);
        wr(8'h30, 32'h408);
        idle(10);
        wr(8'h30, 32'h0);
        rd(8'h10, 32'd12, "R5 count2");
        rd(8'h34, 32'h8, "R5 compare A bit 3 only");

        // R9 interrupt gating
        check("R9 irq ien off", {31'b0, irq}, 32'h0);
        wr(8'h30, 32'h20);
        check("R9 irq ien on", {31'b0, irq}, 32'h1);
        wr(8'h38, 32'h8);
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h38, 32'h0);
        check("R9 irq unmasked", {31'b0, irq}, 32'h1);
        wr(8'h30, 32'h0);
        check("R9 irq ien cleared", {31'b0, irq}, 32'h0);
        wr(8'h34, 32'h0);

        // R4 down count through zero on counter 3
        wr(8'h28, 32'd1000);
        wr(8'h2C, 32'd1000);
        wr(8'h24, 32'd20);
        wr(8'h20, 32'd3);
        wr(8'h30, 32'h40);
        idle(4);
        wr(8'h30, 32'h0);
        rd(8'h20, 32'd18, "R4 count3");
        rd(8'h34, 32'h100, "R4 wrap event bit 8");
        wr(8'h34, 32'h0);

        // R7 external tick source
        wr(8'h00, 32'd0);
        wr(8'h30, 32'h203);
        idle(20);
        rd(8'h00, 32'd0, "R7 no edges no steps");
        for (int i = 0; i < 3; i++) begin
            ext_tick = 1'b1; idle(3);
            ext_tick = 1'b0; idle(3);
        end
        idle(6);
        wr(8'h30, 32'h0);
        rd(8'h00, 32'd3, "R7 three edges");

        // R10 access phase with no setup writes nothing
        paddr = 8'h00; pwdata = 32'd55; pwrite = 1'b1; psel = 1'b1; penable = 1'b1;
        idle(1);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        idle(2);
        rd(8'h00, 32'd3, "R10 no setup no write");

        idle(4);
        if (sbq.size() != 0) check("SB leftover", 32'(sbq.size()), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule